// File: doc/BRIEF.md
# Power-Management Capability Registers

This block is the configuration-space slave for the power-management capability of one PCI function. It answers configuration reads and writes that arrive as a dword address, four byte enables and write data. It advertises a capability list through the status register flag and through the capability pointer. It returns a single capability entry with ID 01h and a null next pointer. It holds the device power state and the wake-up (PME) context: the event-enable bit and the event-status bit.

When software moves the function out of D3 into D0, the block pulses a function reset for one clock. After that pulse the function counts as D0 uninitialized until the next configuration write. The PME enable and PME status bits are not touched by that reset, so a pending wake event survives it. Only the power-on reset input clears them. The PME output stays high while a wake event is both pending and enabled, whatever the power state.

Top module: `pm_cap_regs`

## Requirements
- R1: Dword address 01h (byte offset 04h) reads with bit 20 set, which is bit 4 of the status half-word and flags a capability list. All its other bits read 0.
- R2: Dword address 05h (byte offset 14h) reads the capability base offset in bits 7:0, A0h by default. The upper bits read 0.
- R3: The dword at the capability base reads ID 01h in bits 7:0 and a next pointer of 00h in bits 15:8. Bits 31:16 hold the capabilities word, which is DA02h by default. In that word, bits 2:0 are the version 010b, bit 9 flags D1 support, bit 10 flags D2 support and bits 15:11 are the wake-source mask 11011b.
- R4: In the control/status dword (capability base + 4), bits 1:0 are the power state (00 D0, 01 D1, 10 D2, 11 D3). A write with byte enable 0 loads them. A write of a state that is not supported leaves the field unchanged, and by default D2 is not supported. The field reads 00 after power-on reset.
- R5: Bit 8 of the control/status dword is the PME enable. A write with byte enable 1 loads it, and a write without that enable leaves it unchanged.
- R6: Bit 15 of the control/status dword is the PME status. A high pme_req at a clock edge sets it. A write with byte enable 1 and data bit 15 at 1 clears it. When both happen in the same cycle, the set wins.
- R7: pme_out is high exactly while the PME enable and the PME status are both 1, in any power state.
- R8: func_rst is high for exactly one cycle, starting at the clock edge that accepts a write moving the power state from 11 to 00. No other transition raises it.
- R9: The PME enable and PME status keep their values across func_rst. Power-on reset (rst_por_n low) clears them along with the power state.
- R10: d0_uninit is high after power-on reset and from the edge that raises func_rst. The first configuration write after that point clears it.
- R11: Every other dword address reads 0. So do bits 31:16 and bits 14:9 and 7:2 of the control/status dword. Writes to those places change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, asynchronous, active low |
| cfg_wr | input | 1 | Configuration write strobe for this cycle |
| cfg_addr | input | 6 | Dword address within configuration space |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pme_req | input | 1 | Wake event request, sampled at the clock edge |
| pme_out | output | 1 | Wake event signal to the system |
| func_rst | output | 1 | One-cycle reset to the function on leaving D3 for D0 |
| d0_uninit | output | 1 | Function is in D0 uninitialized |

## Verification
Two pairs of functions can land in the same edge. The first pair is a wake request on pme_req and a software clear of PME status. The bench drives both in one cycle and judges by reading bit 15 back, which must still be 1; a clear alone must then drop it. The second pair is the D3-to-D0 write and the PME context. The bench arms enable and status before the exit and then checks that the context bits and pme_out are unchanged in the very cycle func_rst is high. It also checks that only a later power-on reset clears them.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  // Fixed header locations (dword addresses) the OS walks to find the list
  localparam logic [5:0] STATUS_DW  = 6'h01;
  localparam logic [5:0] CAPPTR_DW  = 6'h05;
  localparam int         CAPFLAG_BIT = 20;   // bit 4 of status half-word
  localparam logic [7:0] PM_CAP_ID  = 8'h01;
  localparam logic [7:0] NEXT_NULL  = 8'h00;
  localparam logic [2:0] PM_VERSION = 3'b010;

  // Field positions in the control/status half-word
  localparam int PME_EN_BIT  = 8;
  localparam int PME_STS_BIT = 15;

  function automatic logic state_ok(logic [1:0] s, bit d1_ok, bit d2_ok);
    case (s)
      2'b01:   state_ok = d1_ok;
      2'b10:   state_ok = d2_ok;
      default: state_ok = 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] pmc_word(bit d1_ok, bit d2_ok, logic [4:0] wake_mask);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = PM_VERSION;
    w[9]     = d1_ok;
    w[10]    = d2_ok;
    w[15:11] = wake_mask;
    return w;
  endfunction

  function automatic logic is_d3_exit(logic [1:0] cur, logic [1:0] nxt);
    return (cur == PS_D3) && (nxt == PS_D0);
  endfunction

endpackage

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
  import pm_cap_pkg::*;
#(
  parameter bit SUP_D1 = 1'b1,
  parameter bit SUP_D2 = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_we,
  input  logic       any_wr,
  input  logic [1:0] st_wd,
  output pstate_e    pstate,
  output logic       func_rst,
  output logic       d0_uninit,
  output logic       d3_exit_ev
);

  logic st_load;

  assign st_load    = st_we && state_ok(st_wd, SUP_D1, SUP_D2);
  assign d3_exit_ev = st_load && is_d3_exit(pstate, st_wd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate    <= PS_D0;
      func_rst  <= 1'b0;
      d0_uninit <= 1'b1;
    end else begin
      if (st_load) pstate <= pstate_e'(st_wd);
      func_rst <= d3_exit_ev;
      if (d3_exit_ev)  d0_uninit <= 1'b1;
      else if (any_wr) d0_uninit <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_pme_ctx.sv
module pm_pme_ctx (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_wd,
  input  logic sts_clr_ev,
  input  logic pme_req,
  output logic pme_en,
  output logic pme_sts
);

  // Only power-on reset reaches these flops; the function reset does not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
    end else begin
      if (en_we) pme_en <= en_wd;
      if (pme_req)         pme_sts <= 1'b1;
      else if (sts_clr_ev) pme_sts <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_cfg_rdmux.sv
module pm_cfg_rdmux
  import pm_cap_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [7:0]  CAP_BASE = 8'hA0,
  parameter logic [15:0] PMC      = 16'h0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  pstate_e           pstate,
  input  logic              pme_en,
  input  logic              pme_sts,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] CAP_DW = ADDR_W'(CAP_BASE >> 2);
  localparam logic [ADDR_W-1:0] CSR_DW = CAP_DW + 1'b1;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STATUS_DW)) begin
      rdata[CAPFLAG_BIT] = 1'b1;
    end else if (addr == ADDR_W'(CAPPTR_DW)) begin
      rdata[7:0] = CAP_BASE;
    end else if (addr == CAP_DW) begin
      rdata = {PMC, NEXT_NULL, PM_CAP_ID};
    end else if (addr == CSR_DW) begin
      rdata[1:0]         = pstate;
      rdata[PME_EN_BIT]  = pme_en;
      rdata[PME_STS_BIT] = pme_sts;
    end
  end

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter logic [7:0] CAP_BASE  = 8'hA0,
  parameter bit         SUP_D1    = 1'b1,
  parameter bit         SUP_D2    = 1'b0,
  parameter logic [4:0] WAKE_MASK = 5'b11011
) (
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              pme_req,
  output logic              pme_out,
  output logic              func_rst,
  output logic              d0_uninit
);

  localparam logic [ADDR_W-1:0] CSR_DW = ADDR_W'(CAP_BASE >> 2) + 1'b1;
  localparam logic [15:0]       PMC    = pmc_word(SUP_D1, SUP_D2, WAKE_MASK);

  // Named internal events, also used by the bound checker
  logic    csr_wr;
  logic    st_we;
  logic    en_we;
  logic    sts_clr_ev;
  logic    d3_exit_ev;
  logic    pme_en;
  logic    pme_sts;
  pstate_e pstate;

  assign csr_wr     = cfg_wr && (cfg_addr == CSR_DW);
  assign st_we      = csr_wr && cfg_be[0];
  assign en_we      = csr_wr && cfg_be[1];
  assign sts_clr_ev = en_we && cfg_wdata[PME_STS_BIT];

  pm_state_ctl #(.SUP_D1(SUP_D1), .SUP_D2(SUP_D2)) u_state (
    .clk        (clk),
    .rst_n      (rst_por_n),
    .st_we      (st_we),
    .any_wr     (cfg_wr),
    .st_wd      (cfg_wdata[1:0]),
    .pstate     (pstate),
    .func_rst   (func_rst),
    .d0_uninit  (d0_uninit),
    .d3_exit_ev (d3_exit_ev)
  );

  pm_pme_ctx u_pme (
    .clk        (clk),
    .rst_n      (rst_por_n),
    .en_we      (en_we),
    .en_wd      (cfg_wdata[PME_EN_BIT]),
    .sts_clr_ev (sts_clr_ev),
    .pme_req    (pme_req),
    .pme_en     (pme_en),
    .pme_sts    (pme_sts)
  );

  pm_cfg_rdmux #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .PMC(PMC)) u_rd (
    .addr    (cfg_addr),
    .pstate  (pstate),
    .pme_en  (pme_en),
    .pme_sts (pme_sts),
    .rdata   (cfg_rdata)
  );

  assign pme_out = pme_en && pme_sts;

endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
  parameter bit SUP_D1 = 1'b1,
  parameter bit SUP_D2 = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pstate,
  input logic       pme_en,
  input logic       pme_sts,
  input logic       pme_req,
  input logic       pme_out,
  input logic       func_rst,
  input logic       d0_uninit,
  input logic       d3_exit_ev,
  input logic       sts_clr_ev
);

  a_r4_supported_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(pstate == 2'b01 && !SUP_D1) && !(pstate == 2'b10 && !SUP_D2));

  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req |=> pme_sts);

  a_r9_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts && !sts_clr_ev) |=> pme_sts);

  a_r7_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pme_out |-> (pme_en && pme_sts));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |=> !func_rst);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    d3_exit_ev |=> (func_rst && pstate == 2'b00));

  a_r10_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |-> d0_uninit);

endmodule

bind pm_cap_regs pm_cap_regs_chk #(.SUP_D1(SUP_D1), .SUP_D2(SUP_D2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_por_n),
  .pstate     (pstate),
  .pme_en     (pme_en),
  .pme_sts    (pme_sts),
  .pme_req    (pme_req),
  .pme_out    (pme_out),
  .func_rst   (func_rst),
  .d0_uninit  (d0_uninit),
  .d3_exit_ev (d3_exit_ev),
  .sts_clr_ev (sts_clr_ev)
);

// File: tb/pm_cap_regs_bench.sv
module pm_cap_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [5:0] CSR = 6'h29;

  // {write, dword addr, byte enables, write data, expected read of addr}
  localparam logic [74:0] VEC [NVEC] = '{
    {1'b0, 6'h01, 4'h0, 32'h0,          32'h0010_0000}, // R1 capability flag
    {1'b0, 6'h05, 4'h0, 32'h0,          32'h0000_00A0}, // R2 pointer
    {1'b0, 6'h28, 4'h0, 32'h0,          32'hDA02_0001}, // R3 header + caps
    {1'b0, CSR,   4'h0, 32'h0,          32'h0000_0000}, // R4 after reset
    {1'b0, 6'h00, 4'h0, 32'h0,          32'h0000_0000}, // R11 other address
    {1'b1, CSR,   4'h1, 32'h0000_0001,  32'h0000_0001}, // R4 go D1
    {1'b1, CSR,   4'h1, 32'h0000_0002,  32'h0000_0001}, // R4 D2 refused
    {1'b1, CSR,   4'h2, 32'h0000_0103,  32'h0000_0101}, // R5 enable only
    {1'b1, CSR,   4'h0, 32'hFFFF_FFFF,  32'h0000_0101}, // R4 R5 no enables
    {1'b1, CSR,   4'h1, 32'h0000_0003,  32'h0000_0103}, // R4 go D3
    {1'b1, 6'h07, 4'hF, 32'hFFFF_FFFF,  32'h0000_0000}, // R11 write elsewhere
    {1'b1, CSR,   4'hF, 32'hFFFF_7EFF,  32'h0000_0003}  // R11 R5 reserved bits
  };

  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pme_req = 1'b0;
  logic        pme_out, func_rst, d0_uninit;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_cap_regs u_pm_cap_regs (
    .clk(clk), .rst_por_n(rst_por_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pme_req(pme_req), .pme_out(pme_out), .func_rst(func_rst),
    .d0_uninit(d0_uninit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one write cycle; returns at the negedge after the capturing edge.
  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; pme_req = req;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; pme_req = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic req_pulse();
    @(negedge clk); pme_req = 1'b1;
    @(negedge clk); pme_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_por_n = 1'b1;
    @(negedge clk);
    // R1 R10 reset state of the outputs
    chk("R10 d0_uninit after POR", {31'b0, d0_uninit}, 32'd1);
    chk("R8 func_rst idle",        {31'b0, func_rst},  32'd0);
    chk("R7 pme_out idle",         {31'b0, pme_out},   32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][74]) wr(VEC[i][73:68], VEC[i][67:64], VEC[i][63:32], 1'b0);
      rd(VEC[i][73:68], r);
      chk($sformatf("vector %0d", i), r, VEC[i][31:0]);
    end
    chk("R10 cleared by write", {31'b0, d0_uninit}, 32'd0);

    // R6 R7: request sets status, output held off while disabled
    req_pulse();
    rd(CSR, r); chk("R6 status set", r, 32'h0000_8003);
    chk("R7 disabled", {31'b0, pme_out}, 32'd0);
    wr(CSR, 4'h2, 32'h0000_0100, 1'b0);
    chk("R7 enabled in D3", {31'b0, pme_out}, 32'd1);

    // R8 R9 R10: D3 -> D0 with armed context
    wr(CSR, 4'h3, 32'h0000_0100, 1'b0);
    chk("R8 pulse high",       {31'b0, func_rst},  32'd1);
    chk("R10 uninit on reset", {31'b0, d0_uninit}, 32'd1);
    chk("R9 pme_out kept",     {31'b0, pme_out},   32'd1);
    rd(CSR, r); chk("R9 context kept", r, 32'h0000_8100);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, func_rst}, 32'd0);
    chk("R10 still uninit",   {31'b0, d0_uninit}, 32'd1);
    wr(6'h00, 4'hF, 32'h0, 1'b0);
    chk("R10 cleared again", {31'b0, d0_uninit}, 32'd0);

    // R8: D1 -> D0 gives no pulse
    wr(CSR, 4'h1, 32'h0000_0001, 1'b0);
    wr(CSR, 4'h1, 32'h0000_0000, 1'b0);
    chk("R8 no pulse from D1", {31'b0, func_rst}, 32'd0);

    // R6: clear and request in one cycle, set wins
    wr(CSR, 4'h2, 32'h0000_8100, 1'b1);
    rd(CSR, r); chk("R6 set wins", r, 32'h0000_8100);
    wr(CSR, 4'h2, 32'h0000_8100, 1'b0);
    rd(CSR, r); chk("R6 W1C", r, 32'h0000_0100);
    chk("R7 low after clear", {31'b0, pme_out}, 32'd0);

    // R9: power-on reset clears the context
    req_pulse();
    wr(CSR, 4'h1, 32'h0000_0003, 1'b0);
    @(negedge clk); rst_por_n = 1'b0;
    @(negedge clk); rst_por_n = 1'b1;
    @(negedge clk);
    rd(CSR, r); chk("R9 POR clears", r, 32'h0000_0000);
    chk("R9 pme_out after POR", {31'b0, pme_out}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule